// File: doc/BRIEF.md
# Gated Timer/Counter with Auto-Reload

This block counts either machine cycles, where one machine cycle lasts twelve clocks, or falling edges on an external event pin. The count is held in a high byte and a low byte. A two-bit mode field chooses how the two bytes form the counter. In one mode they form a single 16-bit counter. In another, five bits of the low byte act as a prescaler for the high byte, giving 13 bits. In the third, the low byte counts alone and is reloaded from the high byte each time it wraps.

Counting runs only while the run input is set. When the gate option is on, counting also requires the external gate pin to be high, so the block can measure how long that pin stays high. Every wrap-around sets a sticky overflow flag. The flag stays set until software clears it or the interrupt is acknowledged. The interrupt request is the flag qualified by an enable input.

Software can load either count byte at any cycle. A load replaces whatever step the counter would have taken in that cycle. In the reload mode, a reload value of 0x06 gives one overflow every 250 machine cycles. Toggling an output on each overflow then gives a 2 kHz square wave from a 12 MHz clock.

Top module: `gated_timer`

## Requirements
- R1: Synchronous reset clears both count bytes and the overflow flag, so `irq` is low.
- R2: With `cnt_ext`=0 and counting allowed, the count advances exactly once every 12 clock cycles, on the machine-cycle boundary. While `run`=0 the count holds.
- R3: With `gate_en`=1, counting is allowed only while `gate_pin`=1. With `gate_en`=0, `gate_pin` has no effect.
- R4: With `cnt_ext`=1, `ext_pin` is sampled once per machine cycle. The count advances once for each sample that is low when the previous sample was high. A low pulse that falls between two samples is not counted.
- R5: Mode 2'b01 (16-bit): {`cnt_hi`,`cnt_lo`} increments as one value and overflows on the step from 0xFFFF to 0x0000.
- R6: Mode 2'b00 (13-bit): `cnt_lo`[4:0] is a prescaler. When it steps past 0x1F it becomes 0 and `cnt_hi` increments. Overflow occurs when `cnt_hi`=0xFF and `cnt_lo`[4:0]=0x1F. `cnt_lo`[7:5] never changes on a step.
- R7: Mode 2'b10 (8-bit auto-reload): `cnt_lo` increments. On a step from 0xFF it takes the value of `cnt_hi` and overflows. `cnt_hi` is unchanged. With `cnt_hi`=0x06, overflows come 250 steps apart.
- R8: `ovf_flag` is set in the cycle after an overflow step. It stays set until a cycle with `flag_clr`=1 or `irq_ack`=1. A new overflow in that same cycle wins over the clear.
- R9: `irq` is high exactly when `ovf_flag`=1 and `irq_en`=1.
- R10: `wr_hi` / `wr_lo` load `wr_data` into the chosen byte at the next edge. Any load cancels the count step and any overflow of that cycle.
- R11: Mode 2'b11 leaves both count bytes and the flag unchanged by counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 2 | 00 13-bit, 01 16-bit, 10 8-bit reload, 11 hold |
| cnt_ext | input | 1 | 1 selects external falling edges as the count source |
| gate_en | input | 1 | 1 makes counting depend on gate_pin |
| run | input | 1 | Counting enable |
| irq_en | input | 1 | Interrupt enable |
| wr_hi | input | 1 | Load wr_data into the high byte |
| wr_lo | input | 1 | Load wr_data into the low byte |
| wr_data | input | 8 | Load value |
| flag_clr | input | 1 | Software clear of the overflow flag |
| irq_ack | input | 1 | Interrupt acknowledge, clears the flag |
| ext_pin | input | 1 | External event pin (already synchronised) |
| gate_pin | input | 1 | External gate pin (already synchronised) |
| cnt_hi | output | 8 | High count byte |
| cnt_lo | output | 8 | Low count byte |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Interrupt request |

## Verification
Directed runs start each counting case on a known machine-cycle boundary.

- Loads just below a wrap point tell apart the three widths. In 16-bit mode the carry passes across both bytes. In 13-bit mode it passes out of a five-bit prescaler and leaves the top three low bits untouched. In reload mode the low byte is refilled from the high byte.
- A full run of 250 machine cycles with reload value 0x06 shows the overflow period.
- Event-pin waveforms mix held levels with a short low glitch placed between two samples. This separates sampled-edge counting from level or raw-edge counting.
- Gate levels, a load that lands on a boundary step, and long random mixes of all inputs are checked cycle by cycle against a reference model in the bench. Together they separate the priority of load over step and of set over clear.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;

    localparam int CNT_W   = 8;
    localparam int PRE13_W = 5;

    typedef enum logic [1:0] {
        MODE_13     = 2'b00,
        MODE_16     = 2'b01,
        MODE_RELOAD = 2'b10,
        MODE_HOLD   = 2'b11
    } tmr_mode_e;

    typedef struct packed {
        logic [CNT_W-1:0] hi;
        logic [CNT_W-1:0] lo;
    } cnt_t;

    typedef struct packed {
        cnt_t nxt;
        logic ovf;
    } step_res_t;

    // One count step for the chosen mode; reports whether it wrapped.
    function automatic step_res_t step_count(tmr_mode_e m, cnt_t c);
        step_res_t r;
        logic [2*CNT_W-1:0] wide;
        r.nxt = c;
        r.ovf = 1'b0;
        wide  = '0;
        case (m)
            MODE_16: begin
                wide  = {c.hi, c.lo} + 1'b1;
                r.nxt = wide;
                r.ovf = &{c.hi, c.lo};
            end
            MODE_13: begin
                if (&c.lo[PRE13_W-1:0]) begin
                    r.nxt.lo[PRE13_W-1:0] = '0;
                    r.nxt.hi              = c.hi + 1'b1;
                    r.ovf                 = &c.hi;
                end else begin
                    r.nxt.lo[PRE13_W-1:0] = c.lo[PRE13_W-1:0] + 1'b1;
                end
            end
            MODE_RELOAD: begin
                if (&c.lo) begin
                    r.nxt.lo = c.hi;
                    r.ovf    = 1'b1;
                end else begin
                    r.nxt.lo = c.lo + 1'b1;
                end
            end
            default: ;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/tmr_tick_gen.sv
`timescale 1ns/1ps
module tmr_tick_gen #(
    parameter int MC_DIV = 12
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic gate_en,
    input  logic gate_pin,
    input  logic cnt_ext,
    input  logic ext_pin,
    output logic step_req
);
    localparam int PRE_W = (MC_DIV > 1) ? $clog2(MC_DIV) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(MC_DIV - 1);

    logic [PRE_W-1:0] pre_q;
    logic             mc_tick;
    logic             samp_q;
    logic             fall_seen;
    logic             allowed;

    assign mc_tick = (pre_q == PRE_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q  <= '0;
            samp_q <= 1'b0;
        end else if (mc_tick) begin
            pre_q  <= '0;
            samp_q <= ext_pin;
        end else begin
            pre_q  <= pre_q + 1'b1;
        end
    end

    // Falling edge: previous machine-cycle sample high, this one low.
    assign fall_seen = mc_tick && samp_q && !ext_pin;
    assign allowed   = run && (!gate_en || gate_pin);
    assign step_req  = allowed && (cnt_ext ? fall_seen : mc_tick);

endmodule

// File: rtl/tmr_count_core.sv
`timescale 1ns/1ps
module tmr_count_core
    import tmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  tmr_mode_e        mode,
    input  logic             step_req,
    input  logic             wr_hi,
    input  logic             wr_lo,
    input  logic [CNT_W-1:0] wr_data,
    output cnt_t             cnt,
    output logic             ovf_pulse
);
    cnt_t      cnt_q;
    step_res_t res;
    logic      any_wr;

    assign any_wr    = wr_hi || wr_lo;
    assign res       = step_count(mode, cnt_q);
    assign ovf_pulse = step_req && !any_wr && res.ovf;
    assign cnt       = cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (any_wr) begin
            if (wr_hi) cnt_q.hi <= wr_data;
            if (wr_lo) cnt_q.lo <= wr_data;
        end else if (step_req) begin
            cnt_q <= res.nxt;
        end
    end

endmodule

// File: rtl/tmr_flag.sv
`timescale 1ns/1ps
module tmr_flag (
    input  logic clk,
    input  logic rst,
    input  logic ovf_pulse,
    input  logic flag_clr,
    input  logic irq_ack,
    input  logic irq_en,
    output logic ovf_flag,
    output logic irq
);
    logic flag_q;

    always_ff @(posedge clk) begin
        if (rst)                       flag_q <= 1'b0;
        else if (ovf_pulse)            flag_q <= 1'b1;
        else if (flag_clr || irq_ack)  flag_q <= 1'b0;
    end

    assign ovf_flag = flag_q;
    assign irq      = flag_q && irq_en;

endmodule

// File: rtl/gated_timer.sv
`timescale 1ns/1ps
module gated_timer
    import tmr_pkg::*;
#(
    parameter int MC_DIV = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       cfg_mode,
    input  logic             cnt_ext,
    input  logic             gate_en,
    input  logic             run,
    input  logic             irq_en,
    input  logic             wr_hi,
    input  logic             wr_lo,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             flag_clr,
    input  logic             irq_ack,
    input  logic             ext_pin,
    input  logic             gate_pin,
    output logic [CNT_W-1:0] cnt_hi,
    output logic [CNT_W-1:0] cnt_lo,
    output logic             ovf_flag,
    output logic             irq
);
    tmr_mode_e mode;
    logic      step_req;
    logic      ovf_pulse;
    cnt_t      cnt;

    assign mode = tmr_mode_e'(cfg_mode);

    tmr_tick_gen #(.MC_DIV(MC_DIV)) u_tick (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .gate_en  (gate_en),
        .gate_pin (gate_pin),
        .cnt_ext  (cnt_ext),
        .ext_pin  (ext_pin),
        .step_req (step_req)
    );

    tmr_count_core u_core (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode),
        .step_req  (step_req),
        .wr_hi     (wr_hi),
        .wr_lo     (wr_lo),
        .wr_data   (wr_data),
        .cnt       (cnt),
        .ovf_pulse (ovf_pulse)
    );

    tmr_flag u_flag (
        .clk       (clk),
        .rst       (rst),
        .ovf_pulse (ovf_pulse),
        .flag_clr  (flag_clr),
        .irq_ack   (irq_ack),
        .irq_en    (irq_en),
        .ovf_flag  (ovf_flag),
        .irq       (irq)
    );

    assign cnt_hi = cnt.hi;
    assign cnt_lo = cnt.lo;

endmodule

// File: rtl/gated_timer_chk.sv
`timescale 1ns/1ps
module gated_timer_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] cfg_mode,
    input logic       gate_en,
    input logic       run,
    input logic       wr_hi,
    input logic       wr_lo,
    input logic [7:0] wr_data,
    input logic       flag_clr,
    input logic       irq_ack,
    input logic       gate_pin,
    input logic [7:0] cnt_hi,
    input logic [7:0] cnt_lo,
    input logic       ovf_flag,
    input logic       ovf_pulse
);
    // R2: no run and no load keeps the count
    p_hold_norun_r2: assert property (@(posedge clk) disable iff (rst)
        (!run && !wr_hi && !wr_lo) |=> ($stable(cnt_hi) && $stable(cnt_lo)));

    // R3: gate closed keeps the count
    p_gate_closed_r3: assert property (@(posedge clk) disable iff (rst)
        (gate_en && !gate_pin && !wr_hi && !wr_lo) |=> ($stable(cnt_hi) && $stable(cnt_lo)));

    // R7: reload refills low byte from high byte
    p_reload_r7: assert property (@(posedge clk) disable iff (rst)
        (cfg_mode == 2'b10 && ovf_pulse) |=> (cnt_lo == $past(cnt_hi)));

    // R8: flag stays set without a clear
    p_flag_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (ovf_flag && !flag_clr && !irq_ack) |=> ovf_flag);

    // R8: clear without a new overflow drops the flag
    p_flag_clear_r8: assert property (@(posedge clk) disable iff (rst)
        ((flag_clr || irq_ack) && !ovf_pulse) |=> !ovf_flag);

    // R10: loads land at the next edge
    p_load_lo_r10: assert property (@(posedge clk) disable iff (rst)
        wr_lo |=> (cnt_lo == $past(wr_data)));
    p_load_hi_r10: assert property (@(posedge clk) disable iff (rst)
        wr_hi |=> (cnt_hi == $past(wr_data)));

    // R11: hold mode never counts
    p_hold_mode_r11: assert property (@(posedge clk) disable iff (rst)
        (cfg_mode == 2'b11 && !wr_hi && !wr_lo) |=> ($stable(cnt_hi) && $stable(cnt_lo)));

endmodule

bind gated_timer gated_timer_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_mode  (cfg_mode),
    .gate_en   (gate_en),
    .run       (run),
    .wr_hi     (wr_hi),
    .wr_lo     (wr_lo),
    .wr_data   (wr_data),
    .flag_clr  (flag_clr),
    .irq_ack   (irq_ack),
    .gate_pin  (gate_pin),
    .cnt_hi    (cnt_hi),
    .cnt_lo    (cnt_lo),
    .ovf_flag  (ovf_flag),
    .ovf_pulse (ovf_pulse)
);

// File: tb/gated_timer_bench.sv
`timescale 1ns/1ps
module gated_timer_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] cfg_mode = 2'b01;
    logic       cnt_ext = 1'b0, gate_en = 1'b0, run = 1'b0, irq_en = 1'b0;
    logic       wr_hi = 1'b0, wr_lo = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       flag_clr = 1'b0, irq_ack = 1'b0;
    logic       ext_pin = 1'b1, gate_pin = 1'b0;
    logic [7:0] cnt_hi, cnt_lo;
    logic       ovf_flag, irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    // reference state
    bit [7:0] m_hi, m_lo;
    bit       m_flag, m_s;
    int       m_pre;

    always #10 clk = ~clk;

    gated_timer u_gated_timer (
        .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cnt_ext(cnt_ext),
        .gate_en(gate_en), .run(run), .irq_en(irq_en), .wr_hi(wr_hi),
        .wr_lo(wr_lo), .wr_data(wr_data), .flag_clr(flag_clr),
        .irq_ack(irq_ack), .ext_pin(ext_pin), .gate_pin(gate_pin),
        .cnt_hi(cnt_hi), .cnt_lo(cnt_lo), .ovf_flag(ovf_flag), .irq(irq)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // One clock: model next state from the inputs, clock, compare.
    task automatic step();
        bit       tick, fall, ok, st, ov, n_flag;
        bit [7:0] n_hi, n_lo;
        bit [15:0] w;
        tick = (m_pre == 11);
        fall = tick && m_s && !ext_pin;
        ok   = run && (!gate_en || gate_pin);
        st   = ok && (cnt_ext ? fall : tick);
        n_hi = m_hi; n_lo = m_lo; ov = 0;
        if (wr_hi || wr_lo) begin
            if (wr_hi) n_hi = wr_data;
            if (wr_lo) n_lo = wr_data;
        end else if (st) begin
            case (cfg_mode)
                2'b01: begin
                    w = {m_hi, m_lo} + 16'd1;
                    n_hi = w[15:8]; n_lo = w[7:0];
                    ov = (m_hi == 8'hFF && m_lo == 8'hFF);
                end
                2'b00: begin
                    if (m_lo[4:0] == 5'h1F) begin
                        n_lo[4:0] = 5'h0; n_hi = m_hi + 8'd1; ov = (m_hi == 8'hFF);
                    end else n_lo[4:0] = m_lo[4:0] + 5'd1;
                end
                2'b10: begin
                    if (m_lo == 8'hFF) begin n_lo = m_hi; ov = 1; end
                    else n_lo = m_lo + 8'd1;
                end
                default: ;
            endcase
        end
        n_flag = ov ? 1'b1 : ((flag_clr || irq_ack) ? 1'b0 : m_flag);
        @(posedge clk);
        #1;
        if (rst) begin
            m_hi = 0; m_lo = 0; m_flag = 0; m_pre = 0; m_s = 0;
        end else begin
            m_hi = n_hi; m_lo = n_lo; m_flag = n_flag;
            if (tick) begin m_pre = 0; m_s = ext_pin; end
            else m_pre = m_pre + 1;
        end
        n_tests++;
        if (cnt_hi !== m_hi || cnt_lo !== m_lo || ovf_flag !== m_flag ||
            irq !== (m_flag && irq_en)) begin
            n_fail++;
            if (n_fail < 20)
                $display("FAIL R2/R5/R6/R7/R8/R9 model: actual %h%h f%b i%b expected %h%h f%b i%b",
                         cnt_hi, cnt_lo, ovf_flag, irq, m_hi, m_lo, m_flag, m_flag && irq_en);
        end
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic load(input bit [7:0] hi, input bit [7:0] lo);
        run = 0;
        wr_hi = 1; wr_lo = 1; wr_data = hi; wr_lo = 0; step();
        wr_hi = 0; wr_lo = 1; wr_data = lo; step();
        wr_lo = 0;
    endtask

    task automatic align();
        while (m_pre != 0) step();
    endtask

    task automatic pulse_clr(input bit use_ack);
        if (use_ack) irq_ack = 1; else flag_clr = 1;
        step();
        irq_ack = 0; flag_clr = 0;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        steps(3);
        rst = 0;
        step();
        // R1 reset state
        chk("R1 cnt_hi", cnt_hi, 0);
        chk("R1 cnt_lo", cnt_lo, 0);
        chk("R1 ovf_flag", ovf_flag, 0);
        chk("R1 irq", irq, 0);

        // R5 16-bit wrap, R9 irq
        cfg_mode = 2'b01; irq_en = 1;
        load(8'hFF, 8'hFE); align(); run = 1;
        steps(12);
        chk("R5 lo after 1 step", cnt_lo, 8'hFF);
        chk("R2 one step per 12 clocks", ovf_flag, 0);
        steps(12);
        chk("R5 wrap value", {cnt_hi, cnt_lo}, 16'h0000);
        chk("R5 overflow flag", ovf_flag, 1);
        chk("R9 irq asserted", irq, 1);

        // R8 sticky, R9 mask
        run = 0; steps(30);
        chk("R8 flag sticky", ovf_flag, 1);
        chk("R2 run=0 holds", {cnt_hi, cnt_lo}, 16'h0000);
        irq_en = 0; step();
        chk("R9 irq masked", irq, 0);
        pulse_clr(0);
        chk("R8 software clear", ovf_flag, 0);
        irq_en = 1;

        // R6 13-bit with upper low bits preserved
        cfg_mode = 2'b00;
        load(8'hFF, 8'hFE); align(); run = 1;
        steps(12);
        chk("R6 prescaler top", {cnt_hi, cnt_lo}, 16'hFFFF);
        steps(12);
        chk("R6 wrap keeps lo[7:5]", {cnt_hi, cnt_lo}, 16'h00E0);
        chk("R6 overflow flag", ovf_flag, 1);
        run = 0; pulse_clr(1);
        chk("R8 ack clear", ovf_flag, 0);

        // R7 reload 0x06 -> 250 steps per overflow
        cfg_mode = 2'b10;
        load(8'h06, 8'h06); align(); run = 1;
        steps(249 * 12);
        chk("R7 before reload lo", cnt_lo, 8'hFF);
        chk("R7 no early overflow", ovf_flag, 0);
        steps(12);
        chk("R7 reloaded lo", cnt_lo, 8'h06);
        chk("R7 hi unchanged", cnt_hi, 8'h06);
        chk("R7 overflow at 250", ovf_flag, 1);
        run = 0; pulse_clr(0);

        // R3 gate
        cfg_mode = 2'b01;
        load(8'h00, 8'h10); align(); run = 1; gate_en = 1; gate_pin = 0;
        steps(24);
        chk("R3 gate low holds", cnt_lo, 8'h10);
        gate_pin = 1; steps(12);
        chk("R3 gate high counts", cnt_lo, 8'h11);
        gate_en = 0; gate_pin = 0; steps(12);
        chk("R3 gate ignored when off", cnt_lo, 8'h12);

        // R10 load on a step cycle
        steps(11);
        wr_lo = 1; wr_data = 8'h40; step(); wr_lo = 0;
        chk("R10 load overrides step", cnt_lo, 8'h40);
        steps(12);
        chk("R10 counting resumes", cnt_lo, 8'h41);

        // R4 external edges: H L L H L H(glitch) H
        load(8'h00, 8'h00); ext_pin = 1; align();
        cnt_ext = 1; run = 1;
        ext_pin = 1; steps(12);
        ext_pin = 0; steps(12);
        steps(12);
        ext_pin = 1; steps(12);
        ext_pin = 0; steps(12);
        ext_pin = 1; steps(2); ext_pin = 0; steps(3); ext_pin = 1; steps(7);
        steps(12);
        chk("R4 sampled falling edges", {cnt_hi, cnt_lo}, 16'h0002);
        cnt_ext = 0;

        // R11 hold mode
        cfg_mode = 2'b11; steps(36);
        chk("R11 hold mode", {cnt_hi, cnt_lo}, 16'h0002);

        // random mix against the model
        for (int i = 0; i < 8000; i++) begin
            if ($urandom % 200 == 0) cfg_mode = 2'($urandom % 4);
            if ($urandom % 100 == 0) cnt_ext = 1'($urandom);
            if ($urandom % 80 == 0)  gate_en = 1'($urandom);
            if ($urandom % 30 == 0)  gate_pin = 1'($urandom);
            if ($urandom % 7 == 0)   ext_pin = 1'($urandom);
            if ($urandom % 60 == 0)  irq_en = 1'($urandom);
            run      = ($urandom % 10) != 0;
            wr_hi    = ($urandom % 60) == 0;
            wr_lo    = ($urandom % 50) == 0;
            wr_data  = 8'($urandom % 256);
            if ($urandom % 3 == 0) wr_data = 8'hF8 | 8'($urandom % 8);
            flag_clr = ($urandom % 70) == 0;
            irq_ack  = ($urandom % 90) == 0;
            step();
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule